// File: doc/BRIEF.md
# Primary Clock Loss Detector with Automatic Failover

This block supervises a primary clock and falls back to a backup clock when the primary goes quiet. Every rising edge of the primary flips a toggle register in the primary domain. That level passes through a two-flop synchronizer into the backup-clock domain, and an edge detector there turns each change into a one-cycle event. A gap counter, clocked by the backup clock, is cleared by each event. If it runs through a whole window of backup cycles with no event, the block raises a loss flag and steers the source select to the backup clock. The window is 3 or 48 backup cycles, chosen by one control pin. The chosen length is captured only when the counter restarts.

Once the primary toggles again, the block does not switch back at the first edge. The first event arms a recovery run. The select returns to the primary only after a full window of backup cycles in which the primary never left a gap as long as the window. A separate combinational gate decodes a two-bit enable code into enables for two output groups and a run signal for the downstream clock synthesizer.

There is no data stream at this block's edge, so every pin is a plain level control or status. Nothing here has a valid/ready handshake or back-pressure.

Top module: `primary_loss_failover`

## Requirements
- R1: After reset, prim_lost and sel_backup are 0, and the captured window is the long one (48 cycles). With the primary silent from reset, the flag is therefore still 0 twenty backup cycles later and is 1 no later than 56 backup cycles after reset.
- R2: While primary rising edges follow each other within the current window, measured in backup cycles, prim_lost stays 0.
- R3: After the last primary rising edge, prim_lost stays 0 for at least W backup cycles and is 1 within W+8 backup cycles, where W is the captured window.
- R4: The window is 3 backup cycles when long_win is 0 and 48 backup cycles when long_win is 1.
- R5: After the primary restarts during a loss, prim_lost is still 1 one backup cycle later. It clears within W+8 backup cycles, once a full window of unbroken primary toggling has been seen.
- R6: A change of long_win has no effect on a window already running. It applies at the next counter restart, which is a primary event or a timeout.
- R7: oe_code bit 0 enables group 0 (grp0_en) and bit 1 enables group 1 (grp1_en). pll_run is 0 only for code 00. The outputs follow the code combinationally.
- R8: sel_backup (1 selects the backup clock, 0 selects the primary) is equal to prim_lost at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_b | input | 1 | Backup clock; all timing logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Primary clock under supervision |
| long_win | input | 1 | Window select: 0 = 3 cycles, 1 = 48 cycles |
| oe_code | input | 2 | Output-group enable code |
| sel_backup | output | 1 | Source select: 1 = backup, 0 = primary |
| prim_lost | output | 1 | Primary-loss status flag |
| grp0_en | output | 1 | Enable for output group 0 (single output) |
| grp1_en | output | 1 | Enable for output group 1 (three outputs) |
| pll_run | output | 1 | Run control for the downstream synthesizer |

## Verification
A primary edge reaches the gap counter as an event two or three backup edges later. The loss flag therefore rises W+1 to W+4 backup edges after the last primary edge, and it falls about the same number of edges after the first edge of a restart. The bench stops the primary right after one of its rising edges. It checks the flag at W backup falling edges, where it must still be low, and again eight cycles later, where it must be high. Recovery gets the same treatment. The gate outputs are combinational, so they are sampled 1 ns after each code change.

// File: rtl/lossdet_pkg.sv
`timescale 1ns/1ps
package lossdet_pkg;
  typedef struct packed {
    logic grp0;
    logic grp1;
    logic pll;
  } gate_t;
endpackage

// File: rtl/a_edge_sync.sv
`timescale 1ns/1ps
module a_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  output logic evt
);
  localparam int SW = STAGES + 1;

  logic tgl;
  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  // synchronizer stages plus one history flop for edge detection
  logic [SW-1:0] sh;
  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SW-2:0], tgl};
  end

  assign evt = sh[SW-1] ^ sh[SW-2];
endmodule

// File: rtl/loss_timer.sv
`timescale 1ns/1ps
module loss_timer #(
  parameter int SHORT_W = 3,
  parameter int LONG_W  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic long_win,
  output logic lost
);
  localparam int CW = $clog2(LONG_W + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, rc, win, next_w;
  logic          armed;

  assign next_w = long_win ? CW'(LONG_W) : CW'(SHORT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rc    <= '0;
      win   <= CW'(LONG_W);
      lost  <= 1'b0;
      armed <= 1'b0;
    end else if (!lost) begin
      armed <= 1'b0;
      rc    <= '0;
      if (evt) begin
        cnt <= '0;
        win <= next_w;
      end else if (cnt == win - ONE) begin
        lost <= 1'b1;
        cnt  <= '0;
        win  <= next_w;
      end else begin
        cnt <= cnt + ONE;
      end
    end else if (evt) begin
      cnt <= '0;
      if (!armed) begin
        armed <= 1'b1;
        rc    <= '0;
        win   <= next_w;
      end else if (rc == win - ONE) begin
        lost  <= 1'b0;
        armed <= 1'b0;
        rc    <= '0;
        win   <= next_w;
      end else begin
        rc <= rc + ONE;
      end
    end else if (armed) begin
      if (cnt == win - ONE) begin
        armed <= 1'b0;   // primary dropped again during recovery
        rc    <= '0;
        cnt   <= '0;
      end else if (rc == win - ONE) begin
        lost  <= 1'b0;
        armed <= 1'b0;
        rc    <= '0;
        cnt   <= '0;
        win   <= next_w;
      end else begin
        cnt <= cnt + ONE;
        rc  <= rc + ONE;
      end
    end
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < win); // R2
  AST_LOSS_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(!evt && cnt == win - ONE)); // R3
  AST_RECOVER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> $past(armed)); // R5
  AST_WIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost && !evt && cnt != win - ONE) |=> $stable(win)); // R6
endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
module out_gate
  import lossdet_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] code,
  output gate_t             g
);
  always_comb begin
    g.grp0 = code[0];
    g.grp1 = code[1];
    g.pll  = |code;
  end
endmodule

// File: rtl/primary_loss_failover.sv
`timescale 1ns/1ps
module primary_loss_failover
  import lossdet_pkg::*;
#(
  parameter int SHORT_W     = 3,
  parameter int LONG_W      = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_b,
  input  logic       rst_n,
  input  logic       clk_a,
  input  logic       long_win,
  input  logic [1:0] oe_code,
  output logic       sel_backup,
  output logic       prim_lost,
  output logic       grp0_en,
  output logic       grp1_en,
  output logic       pll_run
);
  logic  a_evt;
  gate_t gates;

  a_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_a (clk_a),
    .clk_b (clk_b),
    .rst_n (rst_n),
    .evt   (a_evt)
  );

  loss_timer #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_timer (
    .clk      (clk_b),
    .rst_n    (rst_n),
    .evt      (a_evt),
    .long_win (long_win),
    .lost     (prim_lost)
  );

  out_gate #(.CODE_W(2)) u_gate (
    .code (oe_code),
    .g    (gates)
  );

  assign sel_backup = prim_lost;
  assign grp0_en    = gates.grp0;
  assign grp1_en    = gates.grp1;
  assign pll_run    = gates.pll;

  AST_PLL_OFF_GATES: assert property (@(posedge clk_b) disable iff (!rst_n)
    !pll_run |-> (!grp0_en && !grp1_en)); // R7
endmodule

// File: tb/primary_loss_failover_test.sv
`timescale 1ns/1ps
module primary_loss_failover_test;
  logic       clk_b = 1'b0;
  logic       clk_a = 1'b0;
  logic       rst_n = 1'b0;
  logic       long_win = 1'b0;
  logic [1:0] oe_code = 2'b11;
  logic       sel_backup, prim_lost, grp0_en, grp1_en, pll_run;

  int  tests = 0;
  int  fails = 0;
  bit  a_run = 1'b0;
  int  a_half = 8;
  bit  done = 1'b0;

  primary_loss_failover uut (
    .clk_b(clk_b), .rst_n(rst_n), .clk_a(clk_a), .long_win(long_win),
    .oe_code(oe_code), .sel_backup(sel_backup), .prim_lost(prim_lost),
    .grp0_en(grp0_en), .grp1_en(grp1_en), .pll_run(pll_run)
  );

  always #5 clk_b = ~clk_b;

  always begin
    if (a_run) begin
      #(a_half) clk_a = ~clk_a;
    end else begin
      @(posedge clk_b);
    end
  end

  function automatic int win_of(input logic lw);
    return lw ? 48 : 3;
  endfunction

  function automatic logic [2:0] exp_gate(input logic [1:0] c);
    return {c[0], c[1], (c != 2'b00)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_b);
  endtask

  task automatic stop_a();
    @(posedge clk_a);
    a_run = 1'b0;
  endtask

  task automatic gate_check(input logic [1:0] c);
    oe_code = c;
    #1;
    chk("R7 grp0", grp0_en, int'(exp_gate(c)[2]));
    chk("R7 grp1", grp1_en, int'(exp_gate(c)[1]));
    chk("R7 pll",  pll_run, int'(exp_gate(c)[0]));
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd5813);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk("R1 lost", prim_lost, 0);
    chk("R1 sel", sel_backup, 0);
    // R1: default long window with primary silent
    cyc(19);
    chk("R1 long default", prim_lost, 0);
    cyc(36);
    chk("R1 long expiry", prim_lost, 1);
    chk("R8 sel", sel_backup, 1);

    // R7: full enable table, directed
    for (int c = 0; c < 4; c++) gate_check(2'(c));

    // R5: recovery from the silent-start loss
    a_half = 7;
    a_run = 1'b1;
    cyc(1);
    chk("R5 still lost", prim_lost, 1);
    cyc(48 + 8);
    chk("R5 recovered", prim_lost, 0);

    // R4/R3: short window, directed
    long_win = 1'b0;
    cyc(10);
    stop_a();
    cyc(3);
    chk("R4 short hold", prim_lost, 0);
    cyc(8);
    chk("R4 short expiry", prim_lost, 1);

    // R6: change of long_win in the middle of a long window
    long_win = 1'b1;
    a_run = 1'b1;
    cyc(70);
    chk("R6 healthy", prim_lost, 0);
    stop_a();
    cyc(5);
    long_win = 1'b0;
    cyc(15);
    chk("R6 window kept", prim_lost, 0);
    cyc(48 + 8 - 20);
    chk("R6 expiry", prim_lost, 1);

    // random trials
    for (int t = 0; t < 16; t++) begin
      logic lw;
      int   w;
      lw = logic'($urandom % 2);
      w  = win_of(lw);
      long_win = lw;
      a_half = 6 + int'($urandom % 7);
      a_run = 1'b1;
      cyc(1);
      if (prim_lost) chk("R5 random still lost", prim_lost, 1);
      cyc(60 + int'($urandom % 40));
      for (int k = 0; k < 8; k++) begin
        cyc(3);
        chk("R2 no false loss", prim_lost, 0);
        chk("R8 sel", sel_backup, prim_lost);
      end
      gate_check(2'($urandom % 4));
      stop_a();
      cyc(w);
      chk("R3 hold", prim_lost, 0);
      cyc(8);
      chk("R3 expiry", prim_lost, 1);
      chk("R8 sel lost", sel_backup, 1);
      a_run = 1'b1;
      cyc(1);
      chk("R5 not yet", prim_lost, 1);
      cyc(w + 8);
      chk("R5 back", prim_lost, 0);
      chk("R8 sel back", sel_backup, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule